// File: doc/BRIEF.md
# Big-Endian Sub-Word Load/Store Merger

This unit sits between a word-wide memory port and the register file of a processor core. It takes a memory opcode, the low two bits of the effective address, the word already read from memory and the value of the rt register. For a load it returns the value to write back to the register file. For a store it returns the complete 32-bit word to write back to memory. Byte lanes are numbered big-endian, so address offset 0 selects the most significant byte.

It handles byte, halfword and word accesses. It also handles the unaligned left and right word forms. In those forms the fetched bytes are merged into the old register value on a load, and the register bytes are merged into the old memory word on a store. The unit is purely combinational: address generation, memory timing and alignment faults belong to the logic around it. Any opcode it does not recognise raises a flag and forces both results to zero.

Top module: `bsm_merger`

## Requirements
- R1: Opcode 0x20 (signed byte load) returns the byte in lane `a`, where lane 0 is bits 31:24 and lane 3 is bits 7:0, sign-extended from bit 7.
- R2: Opcode 0x24 (unsigned byte load) returns the same lane byte zero-extended, so bits 31:8 are always zero.
- R3: Halfword loads choose the upper half (bits 31:16) when address bit 1 is 0 and the lower half when it is 1. Address bit 0 is ignored. Opcode 0x21 sign-extends the half and 0x25 zero-extends it.
- R4: Opcode 0x22 (left word load) at offset `a` fills result bytes 0 to 3-a with memory bytes a to 3, and keeps the remaining low `a` bytes from rt.
- R5: Opcode 0x26 (right word load) at offset `a` fills result bytes 3-a to 3 with memory bytes 0 to a, and keeps the remaining high 3-a bytes from rt.
- R6: Opcode 0x28 (byte store) writes the low byte of rt into lane `a` of the memory word. The other three bytes keep their memory values.
- R7: Opcode 0x29 (halfword store) writes the low 16 bits of rt into the half chosen by address bit 1, as in R3. The other half keeps its memory value.
- R8: Opcode 0x2A (left word store) at offset `a` writes rt bytes 0 to 3-a into memory bytes a to 3, and keeps memory bytes 0 to a-1.
- R9: Opcode 0x2E (right word store) at offset `a` writes rt bytes 3-a to 3 into memory bytes 0 to a, and keeps memory bytes a+1 to 3.
- R10: Opcodes 0x23 and 0x30 return the memory word unchanged. Opcodes 0x2B and 0x38 output rt unchanged as the store word.
- R11: Every other opcode raises `illegal_op_o` and drives both results to zero.
- R12: Exactly one of `load_valid_o`, `store_valid_o` and `illegal_op_o` is high. The result that does not belong to the active class is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code_i | input | 6 | Primary opcode of the memory instruction |
| addr_lo_i | input | 2 | Byte offset of the effective address within the word |
| mem_word_i | input | 32 | Word read from memory at the aligned address |
| rt_value_i | input | 32 | Current value of the rt register |
| load_data_o | output | 32 | Value to write back to the register file on a load |
| store_data_o | output | 32 | Merged word to write back to memory on a store |
| load_valid_o | output | 1 | Opcode is a recognised load |
| store_valid_o | output | 1 | Opcode is a recognised store |
| illegal_op_o | output | 1 | Opcode is not handled by this unit |

## Verification
The bench focuses on the two ends of the offset range for the unaligned forms. Offset 0 of a left form and offset 3 of a right form must move the whole word. A mask or shift that is off by one lane at those points would leave a stale rt or memory byte in the result. Byte data with bit 7 set and clear is used to catch a swapped sign or zero extension. Halfword accesses at odd offsets are used to catch a design that wrongly decodes address bit 0. The bench also sweeps all 64 opcodes against every offset, so an unlisted opcode that leaked a non-zero result or failed to raise the illegal flag would be reported.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned WORD_W = 32;

  localparam logic [5:0] OP_LB  = 6'h20;
  localparam logic [5:0] OP_LH  = 6'h21;
  localparam logic [5:0] OP_LWL = 6'h22;
  localparam logic [5:0] OP_LW  = 6'h23;
  localparam logic [5:0] OP_LBU = 6'h24;
  localparam logic [5:0] OP_LHU = 6'h25;
  localparam logic [5:0] OP_LWR = 6'h26;
  localparam logic [5:0] OP_SB  = 6'h28;
  localparam logic [5:0] OP_SH  = 6'h29;
  localparam logic [5:0] OP_SWL = 6'h2A;
  localparam logic [5:0] OP_SW  = 6'h2B;
  localparam logic [5:0] OP_SWR = 6'h2E;
  localparam logic [5:0] OP_LL  = 6'h30;
  localparam logic [5:0] OP_SC  = 6'h38;

  typedef enum logic [2:0] {
    K_NONE, K_BYTE, K_HALF, K_WORD, K_LEFT, K_RIGHT
  } acc_kind_e;

  typedef struct packed {
    logic      is_load;
    logic      is_store;
    logic      sext;
    acc_kind_e kind;
  } acc_ctl_t;
endpackage

// File: rtl/bsm_op_decode.sv
module bsm_op_decode
  import bsm_pkg::*;
(
  input  logic [5:0] op_i,
  output acc_ctl_t   ctl_o
);
  timeunit 1ns; timeprecision 1ps;

  always_comb begin
    ctl_o = '{is_load: 1'b0, is_store: 1'b0, sext: 1'b0, kind: K_NONE};
    case (op_i)
      OP_LB:  ctl_o = '{is_load: 1'b1, is_store: 1'b0, sext: 1'b1, kind: K_BYTE};
      OP_LBU: ctl_o = '{is_load: 1'b1, is_store: 1'b0, sext: 1'b0, kind: K_BYTE};
      OP_LH:  ctl_o = '{is_load: 1'b1, is_store: 1'b0, sext: 1'b1, kind: K_HALF};
      OP_LHU: ctl_o = '{is_load: 1'b1, is_store: 1'b0, sext: 1'b0, kind: K_HALF};
      OP_LWL: ctl_o = '{is_load: 1'b1, is_store: 1'b0, sext: 1'b0, kind: K_LEFT};
      OP_LWR: ctl_o = '{is_load: 1'b1, is_store: 1'b0, sext: 1'b0, kind: K_RIGHT};
      OP_LW,
      OP_LL:  ctl_o = '{is_load: 1'b1, is_store: 1'b0, sext: 1'b0, kind: K_WORD};
      OP_SB:  ctl_o = '{is_load: 1'b0, is_store: 1'b1, sext: 1'b0, kind: K_BYTE};
      OP_SH:  ctl_o = '{is_load: 1'b0, is_store: 1'b1, sext: 1'b0, kind: K_HALF};
      OP_SWL: ctl_o = '{is_load: 1'b0, is_store: 1'b1, sext: 1'b0, kind: K_LEFT};
      OP_SWR: ctl_o = '{is_load: 1'b0, is_store: 1'b1, sext: 1'b0, kind: K_RIGHT};
      OP_SW,
      OP_SC:  ctl_o = '{is_load: 1'b0, is_store: 1'b1, sext: 1'b0, kind: K_WORD};
      default: ;
    endcase
  end
endmodule

// File: rtl/bsm_lane_ctrl.sv
module bsm_lane_ctrl #(
  parameter  int unsigned W     = 32,
  localparam int unsigned LANES = W / 8,
  localparam int unsigned OFS_W = $clog2(LANES),
  localparam int unsigned SH_W  = $clog2(W)
) (
  input  logic [OFS_W-1:0] ofs_i,
  output logic [SH_W-1:0]  up_sh_o,   // 8 * offset
  output logic [SH_W-1:0]  dn_sh_o,   // 8 * (last lane - offset)
  output logic [SH_W-1:0]  half_sh_o  // shift that brings the chosen half to the bottom
);
  timeunit 1ns; timeprecision 1ps;

  always_comb begin
    up_sh_o   = SH_W'(8 * 32'(ofs_i));
    dn_sh_o   = SH_W'(8 * (32'(LANES) - 1 - 32'(ofs_i)));
    half_sh_o = SH_W'(8 * (32'(LANES) - 2 - (32'(ofs_i) & 32'hFFFF_FFFE)));
  end
endmodule

// File: rtl/bsm_load_path.sv
module bsm_load_path
  import bsm_pkg::*;
#(
  parameter  int unsigned W    = 32,
  localparam int unsigned SH_W = $clog2(W)
) (
  input  acc_ctl_t        ctl_i,
  input  logic [W-1:0]    mem_i,
  input  logic [W-1:0]    reg_i,
  input  logic [SH_W-1:0] up_sh_i,
  input  logic [SH_W-1:0] dn_sh_i,
  input  logic [SH_W-1:0] half_sh_i,
  output logic [W-1:0]    data_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  function automatic logic [W-1:0] pick_byte(logic [W-1:0] w, logic [SH_W-1:0] sh, logic sx);
    logic [7:0] b;
    b = 8'(w >> sh);
    return sx ? {{(W-8){b[7]}}, b} : {{(W-8){1'b0}}, b};
  endfunction

  function automatic logic [W-1:0] pick_half(logic [W-1:0] w, logic [SH_W-1:0] sh, logic sx);
    logic [15:0] h;
    h = 16'(w >> sh);
    return sx ? {{(W-16){h[15]}}, h} : {{(W-16){1'b0}}, h};
  endfunction

  // bits under sel come from fresh, the rest from old
  function automatic logic [W-1:0] blend(logic [W-1:0] old, logic [W-1:0] fresh, logic [W-1:0] sel);
    return (old & ~sel) | (fresh & sel);
  endfunction

  always_comb begin
    data_o = '0;
    if (ctl_i.is_load) begin
      case (ctl_i.kind)
        K_BYTE:  data_o = pick_byte(mem_i, dn_sh_i, ctl_i.sext);
        K_HALF:  data_o = pick_half(mem_i, half_sh_i, ctl_i.sext);
        K_WORD:  data_o = mem_i;
        K_LEFT:  data_o = blend(reg_i, mem_i << up_sh_i, ALL1 << up_sh_i);
        K_RIGHT: data_o = blend(reg_i, mem_i >> dn_sh_i, ALL1 >> dn_sh_i);
        default: data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/bsm_store_path.sv
module bsm_store_path
  import bsm_pkg::*;
#(
  parameter  int unsigned W    = 32,
  localparam int unsigned SH_W = $clog2(W)
) (
  input  acc_ctl_t        ctl_i,
  input  logic [W-1:0]    mem_i,
  input  logic [W-1:0]    reg_i,
  input  logic [SH_W-1:0] up_sh_i,
  input  logic [SH_W-1:0] dn_sh_i,
  input  logic [SH_W-1:0] half_sh_i,
  output logic [W-1:0]    data_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [W-1:0] ALL1   = {W{1'b1}};
  localparam logic [W-1:0] LOW8   = {{(W-8){1'b0}}, 8'hFF};
  localparam logic [W-1:0] LOW16  = {{(W-16){1'b0}}, 16'hFFFF};

  function automatic logic [W-1:0] blend(logic [W-1:0] old, logic [W-1:0] fresh, logic [W-1:0] sel);
    return (old & ~sel) | (fresh & sel);
  endfunction

  always_comb begin
    data_o = '0;
    if (ctl_i.is_store) begin
      case (ctl_i.kind)
        K_BYTE:  data_o = blend(mem_i, (reg_i & LOW8) << dn_sh_i, LOW8 << dn_sh_i);
        K_HALF:  data_o = blend(mem_i, (reg_i & LOW16) << half_sh_i, LOW16 << half_sh_i);
        K_WORD:  data_o = reg_i;
        K_LEFT:  data_o = blend(mem_i, reg_i >> up_sh_i, ALL1 >> up_sh_i);
        K_RIGHT: data_o = blend(mem_i, reg_i << dn_sh_i, ALL1 << dn_sh_i);
        default: data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/bsm_merger.sv
module bsm_merger
  import bsm_pkg::*;
#(
  parameter  int unsigned DATA_W = WORD_W,
  localparam int unsigned OFS_W  = $clog2(DATA_W / 8)
) (
  input  logic [5:0]        op_code_i,
  input  logic [OFS_W-1:0]  addr_lo_i,
  input  logic [DATA_W-1:0] mem_word_i,
  input  logic [DATA_W-1:0] rt_value_i,
  output logic [DATA_W-1:0] load_data_o,
  output logic [DATA_W-1:0] store_data_o,
  output logic              load_valid_o,
  output logic              store_valid_o,
  output logic              illegal_op_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned SH_W = $clog2(DATA_W);

  acc_ctl_t        dec_ctl;
  logic [SH_W-1:0] up_sh, dn_sh, half_sh;

  bsm_op_decode u_dec (
    .op_i  (op_code_i),
    .ctl_o (dec_ctl)
  );

  bsm_lane_ctrl #(.W(DATA_W)) u_lane (
    .ofs_i     (addr_lo_i),
    .up_sh_o   (up_sh),
    .dn_sh_o   (dn_sh),
    .half_sh_o (half_sh)
  );

  bsm_load_path #(.W(DATA_W)) u_ld (
    .ctl_i     (dec_ctl),
    .mem_i     (mem_word_i),
    .reg_i     (rt_value_i),
    .up_sh_i   (up_sh),
    .dn_sh_i   (dn_sh),
    .half_sh_i (half_sh),
    .data_o    (load_data_o)
  );

  bsm_store_path #(.W(DATA_W)) u_st (
    .ctl_i     (dec_ctl),
    .mem_i     (mem_word_i),
    .reg_i     (rt_value_i),
    .up_sh_i   (up_sh),
    .dn_sh_i   (dn_sh),
    .half_sh_i (half_sh),
    .data_o    (store_data_o)
  );

  assign load_valid_o  = dec_ctl.is_load;
  assign store_valid_o = dec_ctl.is_store;
  assign illegal_op_o  = ~(dec_ctl.is_load | dec_ctl.is_store);
endmodule

// File: rtl/bsm_merge_chk.sv
module bsm_merge_chk #(
  parameter  int unsigned W     = 32,
  localparam int unsigned OFS_W = $clog2(W / 8)
) (
  input logic [5:0]       op_i,
  input logic [OFS_W-1:0] ofs_i,
  input logic [W-1:0]     mem_i,
  input logic [W-1:0]     rt_i,
  input logic [W-1:0]     ld_i,
  input logic [W-1:0]     st_i,
  input logic             lv_i,
  input logic             sv_i,
  input logic             ill_i
);
  timeunit 1ns; timeprecision 1ps;

  logic [W-1:0] byte_lane;
  assign byte_lane = {8'hFF, {(W-8){1'b0}}} >> (8 * 32'(ofs_i));

  always_comb begin
    // R12
    class_onehot_chk: assert ($countones({lv_i, sv_i, ill_i}) == 1)
      else $error("class flags not one-hot");
    // R12
    out_of_class_zero_chk: assert ((!lv_i || st_i == '0) && (!sv_i || ld_i == '0))
      else $error("result of inactive class not zero");
    // R11
    illegal_zero_chk: assert (!ill_i || (ld_i == '0 && st_i == '0))
      else $error("illegal opcode left a non-zero result");
    // R10
    word_load_pass_chk: assert (!(op_i == 6'h23 || op_i == 6'h30) || ld_i == mem_i)
      else $error("word load altered memory word");
    // R10
    word_store_pass_chk: assert (!(op_i == 6'h2B || op_i == 6'h38) || st_i == rt_i)
      else $error("word store altered rt");
    // R2
    byte_zext_chk: assert (op_i != 6'h24 || (ld_i >> 8) == '0)
      else $error("unsigned byte load has high bits set");
    // R6
    byte_store_keep_chk: assert (op_i != 6'h28 || ((st_i ^ mem_i) & ~byte_lane) == '0)
      else $error("byte store disturbed a neighbouring lane");
  end
endmodule

bind bsm_merger bsm_merge_chk #(.W(DATA_W)) u_chk (
  .op_i  (op_code_i),
  .ofs_i (addr_lo_i),
  .mem_i (mem_word_i),
  .rt_i  (rt_value_i),
  .ld_i  (load_data_o),
  .st_i  (store_data_o),
  .lv_i  (load_valid_o),
  .sv_i  (store_valid_o),
  .ill_i (illegal_op_o)
);

// File: tb/bsm_merger_test.sv
module bsm_merger_test;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic [5:0]  op_code;
  logic [1:0]  addr_lo;
  logic [31:0] mem_word, rt_value;
  logic [31:0] load_data, store_data;
  logic        load_valid, store_valid, illegal_op;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  bsm_merger uut (
    .op_code_i     (op_code),
    .addr_lo_i     (addr_lo),
    .mem_word_i    (mem_word),
    .rt_value_i    (rt_value),
    .load_data_o   (load_data),
    .store_data_o  (store_data),
    .load_valid_o  (load_valid),
    .store_valid_o (store_valid),
    .illegal_op_o  (illegal_op)
  );

  localparam logic [2:0] FL_LD = 3'b100, FL_ST = 3'b010, FL_IL = 3'b001;
  localparam logic [31:0] MA = 32'hA1B2C3D4, RA = 32'h11223344;

  typedef struct packed {
    logic [5:0]  op;
    logic [1:0]  a;
    logic [31:0] mem;
    logic [31:0] rt;
    logic [31:0] eld;
    logic [31:0] est;
    logic [2:0]  efl;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{6'h20, 2'd0, MA, RA, 32'hFFFFFFA1, 32'h0, FL_LD, 4'd1},
    '{6'h20, 2'd3, 32'h12345678, RA, 32'h00000078, 32'h0, FL_LD, 4'd1},
    '{6'h20, 2'd2, MA, RA, 32'hFFFFFFC3, 32'h0, FL_LD, 4'd1},
    '{6'h24, 2'd1, MA, RA, 32'h000000B2, 32'h0, FL_LD, 4'd2},
    '{6'h24, 2'd0, MA, RA, 32'h000000A1, 32'h0, FL_LD, 4'd2},
    '{6'h21, 2'd0, MA, RA, 32'hFFFFA1B2, 32'h0, FL_LD, 4'd3},
    '{6'h21, 2'd3, MA, RA, 32'hFFFFC3D4, 32'h0, FL_LD, 4'd3},
    '{6'h25, 2'd1, MA, RA, 32'h0000A1B2, 32'h0, FL_LD, 4'd3},
    '{6'h22, 2'd1, MA, RA, 32'hB2C3D444, 32'h0, FL_LD, 4'd4},
    '{6'h22, 2'd0, MA, RA, 32'hA1B2C3D4, 32'h0, FL_LD, 4'd4},
    '{6'h22, 2'd3, MA, RA, 32'hD4223344, 32'h0, FL_LD, 4'd4},
    '{6'h26, 2'd0, MA, RA, 32'h112233A1, 32'h0, FL_LD, 4'd5},
    '{6'h26, 2'd2, MA, RA, 32'h11A1B2C3, 32'h0, FL_LD, 4'd5},
    '{6'h26, 2'd3, MA, RA, 32'hA1B2C3D4, 32'h0, FL_LD, 4'd5},
    '{6'h28, 2'd2, MA, RA, 32'h0, 32'hA1B244D4, FL_ST, 4'd6},
    '{6'h28, 2'd0, MA, RA, 32'h0, 32'h44B2C3D4, FL_ST, 4'd6},
    '{6'h29, 2'd2, MA, RA, 32'h0, 32'hA1B23344, FL_ST, 4'd7},
    '{6'h29, 2'd1, MA, RA, 32'h0, 32'h3344C3D4, FL_ST, 4'd7},
    '{6'h2A, 2'd1, MA, RA, 32'h0, 32'hA1112233, FL_ST, 4'd8},
    '{6'h2A, 2'd3, MA, RA, 32'h0, 32'hA1B2C311, FL_ST, 4'd8},
    '{6'h2E, 2'd0, MA, RA, 32'h0, 32'h44B2C3D4, FL_ST, 4'd9},
    '{6'h2E, 2'd2, MA, RA, 32'h0, 32'h223344D4, FL_ST, 4'd9},
    '{6'h2E, 2'd3, MA, RA, 32'h0, 32'h11223344, FL_ST, 4'd9},
    '{6'h23, 2'd2, MA, RA, 32'hA1B2C3D4, 32'h0, FL_LD, 4'd10},
    '{6'h30, 2'd1, MA, RA, 32'hA1B2C3D4, 32'h0, FL_LD, 4'd10},
    '{6'h2B, 2'd3, MA, RA, 32'h0, 32'h11223344, FL_ST, 4'd10},
    '{6'h38, 2'd0, MA, RA, 32'h0, 32'h11223344, FL_ST, 4'd10},
    '{6'h27, 2'd1, MA, RA, 32'h0, 32'h0, FL_IL, 4'd11},
    '{6'h00, 2'd0, MA, RA, 32'h0, 32'h0, FL_IL, 4'd11},
    '{6'h3F, 2'd3, MA, RA, 32'h0, 32'h0, FL_IL, 4'd11}
  };

  function automatic string tag_of(logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [3:0] req_of_op(logic [5:0] op);
    case (op)
      6'h20: return 4'd1;  6'h24: return 4'd2;
      6'h21, 6'h25: return 4'd3;
      6'h22: return 4'd4;  6'h26: return 4'd5;
      6'h28: return 4'd6;  6'h29: return 4'd7;
      6'h2A: return 4'd8;  6'h2E: return 4'd9;
      6'h23, 6'h30, 6'h2B, 6'h38: return 4'd10;
      default: return 4'd11;
    endcase
  endfunction

  // Byte-array model: index 0 is the most significant byte.
  function automatic logic [98:0] model(logic [5:0] op, logic [1:0] a,
                                        logic [31:0] mw, logic [31:0] rw);
    logic [7:0] m[4], r[4], o[4];
    logic [31:0] ld, st;
    logic [2:0] fl;
    int ai, hb;
    ai = int'(a);
    hb = ai & 2;
    for (int i = 0; i < 4; i++) begin
      m[i] = mw[31-8*i -: 8];
      r[i] = rw[31-8*i -: 8];
    end
    ld = '0; st = '0; fl = FL_IL;
    case (op)
      6'h20: begin ld = {{24{m[ai][7]}}, m[ai]}; fl = FL_LD; end
      6'h24: begin ld = {24'h0, m[ai]}; fl = FL_LD; end
      6'h21: begin ld = {{16{m[hb][7]}}, m[hb], m[hb+1]}; fl = FL_LD; end
      6'h25: begin ld = {16'h0, m[hb], m[hb+1]}; fl = FL_LD; end
      6'h22: begin
        for (int i = 0; i < 4; i++) o[i] = (i < 4 - ai) ? m[i+ai] : r[i];
        ld = {o[0], o[1], o[2], o[3]}; fl = FL_LD;
      end
      6'h26: begin
        for (int i = 0; i < 4; i++) o[i] = (i >= 3 - ai) ? m[i-(3-ai)] : r[i];
        ld = {o[0], o[1], o[2], o[3]}; fl = FL_LD;
      end
      6'h23, 6'h30: begin ld = mw; fl = FL_LD; end
      6'h28: begin
        for (int i = 0; i < 4; i++) o[i] = m[i];
        o[ai] = r[3];
        st = {o[0], o[1], o[2], o[3]}; fl = FL_ST;
      end
      6'h29: begin
        for (int i = 0; i < 4; i++) o[i] = m[i];
        o[hb] = r[2]; o[hb+1] = r[3];
        st = {o[0], o[1], o[2], o[3]}; fl = FL_ST;
      end
      6'h2A: begin
        for (int i = 0; i < 4; i++) o[i] = (i >= ai) ? r[i-ai] : m[i];
        st = {o[0], o[1], o[2], o[3]}; fl = FL_ST;
      end
      6'h2E: begin
        for (int i = 0; i < 4; i++) o[i] = (i <= ai) ? r[i+3-ai] : m[i];
        st = {o[0], o[1], o[2], o[3]}; fl = FL_ST;
      end
      6'h2B, 6'h38: begin st = rw; fl = FL_ST; end
      default: ;
    endcase
    return {ld, st, fl, 32'h0};
  endfunction

  task automatic apply(logic [5:0] op, logic [1:0] a, logic [31:0] mw, logic [31:0] rw);
    @(posedge clk);
    op_code = op; addr_lo = a; mem_word = mw; rt_value = rw;
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] eld, logic [31:0] est, logic [2:0] efl);
    n_checks++;
    if (load_data !== eld || store_data !== est ||
        {load_valid, store_valid, illegal_op} !== efl) begin
      n_fail++;
      $display("FAIL %s op=%h a=%0d: ld=%h st=%h fl=%b expected ld=%h st=%h fl=%b",
               tag, op_code, addr_lo, load_data, store_data,
               {load_valid, store_valid, illegal_op}, eld, est, efl);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R12 watchdog: cycles=%0d expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    op_code = 6'h0; addr_lo = 2'd0; mem_word = '0; rt_value = '0;

    // Hand-computed table, R1 through R11
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].mem, VECS[i].rt);
      check(tag_of(VECS[i].req), VECS[i].eld, VECS[i].est, VECS[i].efl);
    end

    // Sweep of every opcode and offset against the byte model (R1-style
    // class checks per opcode, plus R12 flag and inactive-result zeros)
    for (int p = 0; p < 3; p++) begin
      logic [31:0] mw, rw;
      case (p)
        0: begin mw = 32'hA1B2C3D4; rw = 32'h11223344; end
        1: begin mw = 32'h7F00FF80; rw = 32'h80FF007F; end
        default: begin mw = 32'hFFFFFFFF; rw = 32'h00000000; end
      endcase
      for (int op = 0; op < 64; op++) begin
        for (int a = 0; a < 4; a++) begin
          logic [98:0] e;
          e = model(6'(op), 2'(a), mw, rw);
          apply(6'(op), 2'(a), mw, rw);
          check(tag_of(req_of_op(6'(op))), e[98:67], e[66:35], e[34:32]);
        end
      end
    end

    // R12: directed inactive-class zero with dense data
    apply(6'h28, 2'd3, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check("R12", 32'h0, 32'hFFFFFFFF, FL_ST);
    apply(6'h22, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check("R12", 32'hFFFFFFFF, 32'h0, FL_LD);

    finish_run();
  end
endmodule